// File: doc/BRIEF.md
# Clocked Shift-Register Serial Port

This block moves fixed-length words between a parallel interface and a pair of serial data lines. A single serial clock drives both shift registers. The transmit side shifts out a word while the receive side shifts one in, with the same edges. The port carries no frame or word-sync line. Word boundaries come only from an internal bit counter. If one edge is lost or one extra edge arrives, every word after that point is misaligned, and the port raises no error. The only way to restore alignment is a soft reset of the port.

The clock can come from one of two sources. In master operation the port divides the system clock, drives the result on a shared clock pin, and turns the pin's output enable on. In slave operation it reads the same pin. It passes the pin through a two-stage synchronizer and detects edges in the system clock domain. A 3-bit format field enables the port only at code 000. On the parallel side, software writes a transmit holding register and reads a receive data register. A flag reports when the holding register is empty and another reports when received data is ready.

Top module: `sync_shift_port`

## Requirements
- R1: The port is active only when `fmt` equals 3'b000. With any other code, `sclk_oe` is 0, `sclk_out` stays 1, clock edges on `sclk_in` have no effect, and `rx_full` never sets.
- R2: When `fmt`=000 and both `tx_clk_ext` and `rx_clk_ext` are 0, the port is master. `sclk_oe` is 1, and each high phase and each low phase of `sclk_out` lasts `div`+1 system clock cycles.
- R3: When `fmt`=000 and both selects are 1, the port is slave. `sclk_oe` is 0 and the port shifts on edges of `sclk_in`. When the two selects differ, the port stays inactive, as in R1.
- R4: Words are `WORD_W` bits long (8 by default) and are shifted least significant bit first. `sdo` changes only after a falling serial clock edge. `sdi` is sampled on rising edges. Both directions use the same edges.
- R5: In master operation `sclk_out` idles high. It toggles only while the holding register is full or a word is in progress. After reset `sdo` is 1.
- R6: `tx_empty` clears on the cycle after `tx_load`. It sets again when the first falling edge of a word moves the holding register into the shift register. If the holding register is empty at that edge, the port shifts out all ones.
- R7: `rx_full` sets on the cycle after the `WORD_W`th rising edge of a word, and `rx_data` then holds that word. A pulse on `rx_read` clears `rx_full`.
- R8: A stray extra clock pulse moves the word boundary. The next `rx_data` then holds the stray bit in bit 0 and the first `WORD_W`-1 bits of the following word above it, and no error indication appears.
- R9: `soft_rst` clears the bit counter, both shift registers, the master clock divider, `rx_full` and the holding register. It sets `tx_empty` and `sclk_out` to 1, and the next word is aligned again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous port reset that restores word alignment |
| fmt | input | 3 | Word-format code; 000 selects shift-register operation |
| tx_clk_ext | input | 1 | Transmit clock source select, 1 = external pin |
| rx_clk_ext | input | 1 | Receive clock source select, 1 = external pin |
| div | input | DIV_W | Master half-period divisor (half period = div+1 cycles) |
| tx_load | input | 1 | Write `tx_data` into the holding register |
| tx_data | input | WORD_W | Parallel transmit word |
| tx_empty | output | 1 | Holding register can accept a word |
| rx_read | input | 1 | Acknowledge the received word and clear `rx_full` |
| rx_data | output | WORD_W | Last received word |
| rx_full | output | 1 | A received word is waiting |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sclk_in | input | 1 | Clock pin input (slave source) |
| sclk_out | output | 1 | Clock pin output value (master) |
| sclk_oe | output | 1 | Clock pin output enable |

## Verification
The bench builds the port with WORD_W=8 and DIV_W=4. The 4-bit divisor field brings every divisor, including the maximum of 15, into a sweep that measures each half period. In master mode, `sdo` is looped back into `sdi` and all 256 byte values are sent. An independent monitor rebuilds each word from `sdo` on rising clock edges, which confirms the bit order. Slave runs drive the clock pin by hand, which makes stray pulses, disabled formats and mixed clock selects easy to reach.

// File: rtl/sspt_pkg.sv
package sspt_pkg;

  typedef enum logic [1:0] {
    MD_OFF    = 2'd0,
    MD_MASTER = 2'd1,
    MD_SLAVE  = 2'd2
  } mode_e;

  localparam logic [2:0] FMT_SHIFT = 3'b000;

  // Operating mode from the format code and the two clock-source selects.
  function automatic mode_e decode_mode(input logic [2:0] fmt,
                                        input logic tx_ext,
                                        input logic rx_ext);
    if (fmt != FMT_SHIFT)        return MD_OFF;
    if (!tx_ext && !rx_ext)      return MD_MASTER;
    if (tx_ext && rx_ext)        return MD_SLAVE;
    return MD_OFF;
  endfunction

  // True when a bit count marks the final bit of a word.
  function automatic logic is_last_bit(input int unsigned cnt,
                                       input int unsigned word_w);
    return cnt == word_w - 1;
  endfunction

endpackage

// File: rtl/sspt_clkgen.sv
module sspt_clkgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             active,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             ev_rise,
  output logic             ev_fall
);
  logic [DIV_W-1:0] dcnt;
  logic             sclk_q;
  logic             go;
  logic             tick;

  // Keep toggling while work is pending; always finish a low phase.
  assign go      = active && (run || !sclk_q);
  assign tick    = go && (dcnt == div);
  assign ev_fall = tick && sclk_q;
  assign ev_rise = tick && !sclk_q;
  assign sclk    = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      sclk_q <= 1'b1;
    end else if (soft_rst || !active) begin
      dcnt   <= '0;
      sclk_q <= 1'b1;
    end else if (go) begin
      if (tick) begin
        dcnt   <= '0;
        sclk_q <= !sclk_q;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end else begin
      dcnt <= '0;
    end
  end
endmodule

// File: rtl/sspt_edge_sync.sv
module sspt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic pin,
  output logic ev_rise,
  output logic ev_fall
);
  // Two synchronizing stages plus one history stage for edge detection.
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], pin};
  end

  assign ev_rise = active &&  sync_q[1] && !sync_q[2];
  assign ev_fall = active && !sync_q[1] &&  sync_q[2];
endmodule

// File: rtl/sspt_shifter.sv
module sspt_shifter
  import sspt_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rx_read,
  input  logic              sdi,
  output logic              tx_empty,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  output logic              sdo,
  output logic              pending,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              word_done,
  output logic              tx_xfer
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_full_q;
  logic [WORD_W-1:0] txsh_q;
  logic [WORD_W-1:0] rxsh_q;
  logic [WORD_W-1:0] rx_next;
  logic [WORD_W-1:0] fill;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q;
  logic              rxf_q;
  logic [WORD_W-1:0] rxd_q;
  logic              word_start;
  logic              last_bit;

  assign last_bit   = is_last_bit(int'(cnt_q), WORD_W);
  assign word_start = ev_fall && (cnt_q == '0);
  assign tx_xfer    = word_start && hold_full_q;
  assign word_done  = ev_rise && last_bit;
  assign fill       = hold_full_q ? hold_q : '1;
  assign rx_next    = {sdi, rxsh_q[WORD_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      txsh_q      <= '1;
      rxsh_q      <= '0;
      cnt_q       <= '0;
      sdo_q       <= 1'b1;
      rxf_q       <= 1'b0;
      rxd_q       <= '0;
    end else if (soft_rst) begin
      hold_full_q <= 1'b0;
      txsh_q      <= '1;
      rxsh_q      <= '0;
      cnt_q       <= '0;
      rxf_q       <= 1'b0;
    end else begin
      if (tx_load) begin
        hold_q      <= tx_data;
        hold_full_q <= 1'b1;
      end else if (tx_xfer) begin
        hold_full_q <= 1'b0;
      end

      if (ev_fall) begin
        if (cnt_q == '0) begin
          sdo_q  <= fill[0];
          txsh_q <= {1'b1, fill[WORD_W-1:1]};
        end else begin
          sdo_q  <= txsh_q[0];
          txsh_q <= {1'b1, txsh_q[WORD_W-1:1]};
        end
      end

      if (ev_rise) begin
        rxsh_q <= rx_next;
        cnt_q  <= last_bit ? '0 : cnt_q + 1'b1;
        if (last_bit) rxd_q <= rx_next;
      end

      if (word_done)    rxf_q <= 1'b1;
      else if (rx_read) rxf_q <= 1'b0;
    end
  end

  assign tx_empty = !hold_full_q;
  assign rx_data  = rxd_q;
  assign rx_full  = rxf_q;
  assign sdo      = sdo_q;
  assign bit_cnt  = cnt_q;
  assign pending  = hold_full_q || (cnt_q != '0);
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import sspt_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [2:0]        fmt,
  input  logic              tx_clk_ext,
  input  logic              rx_clk_ext,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_empty,
  input  logic              rx_read,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  input  logic              sdi,
  output logic              sdo,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  mode_e            mode;
  logic             is_master;
  logic             is_slave;
  logic             port_en;
  logic             m_rise, m_fall, s_rise, s_fall;
  logic             ev_rise, ev_fall;
  logic             pending;
  logic             word_done;
  logic             tx_xfer;
  logic [CNT_W-1:0] bit_cnt;

  assign mode      = decode_mode(fmt, tx_clk_ext, rx_clk_ext);
  assign is_master = (mode == MD_MASTER);
  assign is_slave  = (mode == MD_SLAVE);
  assign port_en   = is_master || is_slave;
  assign ev_rise   = m_rise || s_rise;
  assign ev_fall   = m_fall || s_fall;
  assign sclk_oe   = is_master;

  sspt_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .active   (is_master),
    .run      (pending),
    .div      (div),
    .sclk     (sclk_out),
    .ev_rise  (m_rise),
    .ev_fall  (m_fall)
  );

  sspt_edge_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (is_slave),
    .pin     (sclk_in),
    .ev_rise (s_rise),
    .ev_fall (s_fall)
  );

  sspt_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .tx_load   (tx_load),
    .tx_data   (tx_data),
    .rx_read   (rx_read),
    .sdi       (sdi),
    .tx_empty  (tx_empty),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .sdo       (sdo),
    .pending   (pending),
    .bit_cnt   (bit_cnt),
    .word_done (word_done),
    .tx_xfer   (tx_xfer)
  );
endmodule

// File: rtl/sspt_chk.sv
module sspt_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             tx_load,
  input logic             port_en,
  input logic             ev_rise,
  input logic             ev_fall,
  input logic             word_done,
  input logic             tx_xfer,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdo,
  input logic             rx_full,
  input logic             tx_empty,
  input logic             sclk_out,
  input logic             sclk_oe
);
  AST_OFF_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !(ev_rise || ev_fall)); // R1

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rise, ev_fall})); // R4

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fall && !soft_rst) |=> $stable(sdo)); // R4

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && sclk_out && tx_empty && !tx_load && bit_cnt == '0 && !soft_rst)
      |=> sclk_out); // R5

  AST_TX_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_xfer && !tx_load && !soft_rst) |=> tx_empty); // R6

  AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !soft_rst) |=> rx_full); // R7

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (bit_cnt == '0 && !rx_full && tx_empty && sclk_out)); // R9
endmodule

bind sync_shift_port sspt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .tx_load   (tx_load),
  .port_en   (port_en),
  .ev_rise   (ev_rise),
  .ev_fall   (ev_fall),
  .word_done (word_done),
  .tx_xfer   (tx_xfer),
  .bit_cnt   (bit_cnt),
  .sdo       (sdo),
  .rx_full   (rx_full),
  .tx_empty  (tx_empty),
  .sclk_out  (sclk_out),
  .sclk_oe   (sclk_oe)
);

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;
  localparam int W  = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic [2:0]    fmt = 3'b000;
  logic          tx_clk_ext = 1'b0;
  logic          rx_clk_ext = 1'b0;
  logic [DW-1:0] div = '0;
  logic          tx_load = 1'b0;
  logic [W-1:0]  tx_data = '0;
  logic          tx_empty;
  logic          rx_read = 1'b0;
  logic [W-1:0]  rx_data;
  logic          rx_full;
  logic          sdo;
  logic          sdi_drv = 1'b0;
  logic          loop_sel = 1'b1;
  logic          sdi;
  logic          sclk_in = 1'b1;
  logic          sclk_out;
  logic          sclk_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic         mon_en = 1'b0;
  logic [W-1:0] mon_sh = '0;

  assign sdi = loop_sel ? sdo : sdi_drv;

  always #2 clk = !clk;

  sync_shift_port #(.WORD_W(W), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fmt(fmt),
    .tx_clk_ext(tx_clk_ext), .rx_clk_ext(rx_clk_ext), .div(div),
    .tx_load(tx_load), .tx_data(tx_data), .tx_empty(tx_empty),
    .rx_read(rx_read), .rx_data(rx_data), .rx_full(rx_full),
    .sdi(sdi), .sdo(sdo), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe)
  );

  // Independent view of the line: rebuild each word LSB first from sdo on rising edges.
  always @(posedge sclk_out) if (mon_en) mon_sh <= {sdo, mon_sh[W-1:1]};

  task automatic chk(input logic ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] f, input logic te, input logic re,
                     input logic [DW-1:0] d);
    @(negedge clk);
    fmt = f; tx_clk_ext = te; rx_clk_ext = re; div = d;
  endtask

  task automatic load(input logic [W-1:0] v);
    @(negedge clk); tx_data = v; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic read_ack();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic wait_full(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rx_full) begin seen = 1; break; end
    end
  endtask

  // One slave clock pulse: fall, present sdi, sample sdo before the rise.
  task automatic spulse(input logic b, output logic seen_sdo);
    @(negedge clk); sclk_in = 1'b0; sdi_drv = b;
    repeat (6) @(negedge clk);
    seen_sdo = sdo;
    sclk_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit            seen;
    logic          so;
    logic [W-1:0]  got_tx;
    int            n;

    repeat (3) @(negedge clk);
    // Reset state, master configuration (R5, R6, R7, R2)
    chk(tx_empty == 1'b1, "R6 reset tx_empty", 32'(tx_empty), 1);
    chk(rx_full == 1'b0, "R7 reset rx_full", 32'(rx_full), 0);
    chk(sdo == 1'b1, "R5 reset sdo", 32'(sdo), 1);
    chk(sclk_out == 1'b1, "R5 reset sclk_out", 32'(sclk_out), 1);
    chk(sclk_oe == 1'b1, "R2 master oe", 32'(sclk_oe), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Exhaustive loopback sweep of every word value at div 0 (R4, R7)
    mon_en = 1'b1;
    for (int v = 0; v < (1 << W); v++) begin
      load(W'(v));
      wait_full(seen);
      chk(seen && rx_data == W'(v), "R7 loopback rx_data", 32'(rx_data), 32'(v));
      chk(mon_sh == W'(v), "R4 lsb-first line order", 32'(mon_sh), 32'(v));
      read_ack();
      chk(rx_full == 1'b0, "R7 rx_read clears", 32'(rx_full), 0);
    end

    // Half-period sweep over every divisor, plus tx_empty timing (R2, R6)
    for (int d = 0; d < (1 << DW); d++) begin
      cfg(3'b000, 1'b0, 1'b0, DW'(d));
      @(negedge clk); tx_data = W'(8'hA5 ^ d); tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
      chk(tx_empty == 1'b0, "R6 tx_empty clears on load", 32'(tx_empty), 0);
      n = 0;
      while (sclk_out && n < 100) begin @(negedge clk); n++; end
      chk(tx_empty == 1'b1, "R6 tx_empty sets at first fall", 32'(tx_empty), 1);
      n = 0;
      while (!sclk_out && n < 100) begin @(negedge clk); n++; end
      chk(n == d + 1, "R2 low half-period", 32'(n), 32'(d + 1));
      n = 0;
      while (sclk_out && n < 100) begin @(negedge clk); n++; end
      chk(n == d + 1, "R2 high half-period", 32'(n), 32'(d + 1));
      wait_full(seen);
      chk(seen && rx_data == W'(8'hA5 ^ d), "R2 word at divisor", 32'(rx_data),
          32'(8'hA5 ^ d));
      read_ack();
    end

    // Idle high with nothing pending (R5)
    seen = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sclk_out) seen = 0;
    end
    chk(seen, "R5 clock idles high", 32'(sclk_out), 1);

    // Soft reset in the middle of a word, then a clean word (R9)
    cfg(3'b000, 1'b0, 1'b0, DW'(3));
    load(8'h3C);
    repeat (12) @(negedge clk);
    load(8'h11);
    pulse_soft();
    chk(sclk_out == 1'b1, "R9 sclk_out high", 32'(sclk_out), 1);
    chk(tx_empty == 1'b1, "R9 holding cleared", 32'(tx_empty), 1);
    chk(rx_full == 1'b0, "R9 rx_full cleared", 32'(rx_full), 0);
    load(8'hC6);
    wait_full(seen);
    chk(seen && rx_data == 8'hC6, "R9 aligned after soft reset", 32'(rx_data), 32'hC6);
    read_ack();
    mon_en = 1'b0;

    // Disabled format code in master selects (R1)
    cfg(3'b001, 1'b0, 1'b0, DW'(0));
    load(8'h77);
    seen = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!sclk_out || sclk_oe) seen = 0;
    end
    chk(seen, "R1 no clock when fmt!=000", 32'(sclk_out), 1);
    chk(tx_empty == 1'b0, "R1 holding untouched", 32'(tx_empty), 0);
    pulse_soft();

    // Mixed clock selects stay inactive (R3)
    cfg(3'b000, 1'b1, 1'b0, DW'(0));
    load(8'h5A);
    seen = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!sclk_out || sclk_oe) seen = 0;
    end
    chk(seen, "R3 mixed selects inactive", 32'(sclk_oe), 0);
    pulse_soft();

    // Slave transfers in both directions (R3, R4, R6)
    loop_sel = 1'b0;
    cfg(3'b000, 1'b1, 1'b1, DW'(0));
    repeat (4) @(negedge clk);
    chk(sclk_oe == 1'b0, "R3 slave oe low", 32'(sclk_oe), 0);
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] tv, rv;
      tv = W'(8'h1D * (k + 3));
      rv = W'(8'hB3 ^ (k * 37));
      load(tv);
      got_tx = '0;
      for (int b = 0; b < W; b++) begin
        spulse(rv[b], so);
        got_tx[b] = so;
        if (b == 0) chk(tx_empty == 1'b1, "R6 slave transfer empties", 32'(tx_empty), 1);
      end
      repeat (2) @(negedge clk);
      chk(rx_full && rx_data == rv, "R3 slave rx_data", 32'(rx_data), 32'(rv));
      chk(got_tx == tv, "R4 slave sdo order", 32'(got_tx), 32'(tv));
      read_ack();
    end

    // Stray pulse misaligns with no error (R8), soft reset recovers (R9)
    spulse(1'b0, so);
    for (int b = 0; b < W - 1; b++) spulse(1'(8'h9B >> b), so);
    repeat (2) @(negedge clk);
    chk(rx_full && rx_data == {7'h1B, 1'b0}, "R8 shifted word",
        32'(rx_data), 32'({7'h1B, 1'b0}));
    read_ack();
    spulse(1'b1, so);
    pulse_soft();
    for (int b = 0; b < W; b++) spulse(1'(8'h9B >> b), so);
    repeat (2) @(negedge clk);
    chk(rx_full && rx_data == 8'h9B, "R9 slave realigned", 32'(rx_data), 32'h9B);
    read_ack();

    // Slave selects but disabled format: pin edges ignored (R1)
    cfg(3'b100, 1'b1, 1'b1, DW'(0));
    for (int b = 0; b < W; b++) spulse(1'b1, so);
    repeat (2) @(negedge clk);
    chk(rx_full == 1'b0, "R1 slave edges ignored", 32'(rx_full), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule